// File: doc/BRIEF.md
# Opcode-Fetch Wait-State Stretcher with ROM/RAM Select

This block sits beside a Z80-style processor and watches its active-low memory strobes. It pulls the processor's active-low WAIT input low for one clock so that slow memory gets one extra access state. In its default setting it stretches only opcode-fetch cycles, where M1 and MREQ are low together. Those are the cycles with the least access time. Other memory reads and writes already have half a clock of extra margin, so they run at full speed. A static mode pin switches the block to stretch every memory access by one state.

WAIT is taken low on the rising clock edge where a qualifying MREQ is first seen, which is the T1-to-T2 edge. It goes high again on the next rising edge, so the processor samples it low at exactly one falling edge and adds one Tw state. A second flip-flop records that the wait has been issued. That flag is cleared only when MREQ returns high, so a long cycle can never earn a second wait.

The same block decodes chip selects for a 1 KB ROM at 0000h–03FFh and a 256-byte RAM at 0400h–04FFh. One address bit picks between the two, and MREQ qualifies both selects. The RAM is built as two 4-bit-wide halves. Each half gets its own select line, and a write strobe gives the RAM its direction.

Top module: `bus_wait_stretcher`

## Requirements
- R1: While rst_n is low, wait_n is high. After reset releases, no wait is pending and the issued flag is clear.
- R2: With mode_all_n high, a cycle with mreq_n and m1_n both low drives wait_n low for exactly one clock. wait_n falls on the first rising edge at which both strobes are sampled low, and it rises on the following rising edge.
- R3: With mode_all_n high, a memory cycle with m1_n high (a plain read or write) leaves wait_n high for the whole cycle.
- R4: With mode_all_n low, every memory cycle (mreq_n low), whether fetch, read or write, drives wait_n low for exactly one clock, with the same timing as R2.
- R5: Within one low period of mreq_n, wait_n goes low at most once, however many clocks the period lasts. A fresh wait needs mreq_n to be sampled high at one rising edge.
- R6: A cycle with mreq_n high, such as an I/O cycle with rd_n or wr_n low, never drives wait_n low in either mode.
- R7: rom_cs_n is low exactly when mreq_n is low, rd_n is low and address bit 10 is 0. This covers 0000h–03FFh.
- R8: Every bit of ram_cs_n is low exactly when mreq_n is low and address bit 10 is 1, for reads and for writes. This covers 0400h–04FFh. ram_wr_n is low only when the RAM is selected and wr_n is low.
- R9: Only address bit 10 is decoded. All other address bits, for example bit 11 of 0800h, have no effect on the selects.
- R10: With mreq_n high, no chip select is active, whatever the address and read/write strobes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_n | input | 1 | Active-low opcode-fetch strobe |
| mreq_n | input | 1 | Active-low memory-request strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mode_all_n | input | 1 | Static mode pin. Low stretches all memory cycles; high stretches fetches only |
| addr | input | ADDR_W (16) | Processor address bus |
| wait_n | output | 1 | Active-low wait request to the processor |
| rom_cs_n | output | 1 | Active-low ROM select |
| ram_cs_n | output | RAM_SLICES (2) | Active-low select, one per 4-bit RAM half |
| ram_wr_n | output | 1 | Active-low RAM write direction |

## Verification
Two functions can fall on the same rising edge: clearing the issued flag when MREQ returns high, and starting a new wait when MREQ is seen low again. Back-to-back memory cycles with MREQ high for exactly one clock edge provoke this. Each cycle must still get exactly one wait. The bench counts the wait_n-low samples per cycle and requires the first low sample in the first clock of each cycle. A stretched long cycle with the same count of one guards the other direction, where the flag is not cleared while MREQ stays low.

// File: rtl/bws_pkg.sv
package bws_pkg;

   typedef enum logic {
      BWS_FETCH_ONLY = 1'b0,
      BWS_ALL_MEM    = 1'b1
   } bws_mode_e;

   typedef struct packed {
      logic rom_sel;
      logic ram_sel;
      logic ram_write;
   } bws_sel_t;

   function automatic bws_mode_e bws_decode_mode(input logic all_n);
      return all_n ? BWS_FETCH_ONLY : BWS_ALL_MEM;
   endfunction

endpackage

// File: rtl/bws_wait_fsm.sv
module bws_wait_fsm
   import bws_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mreq_act,
   input  logic      fetch_act,
   input  bws_mode_e mode,
   output logic      wait_act
);

   logic qualify;
   logic wait_q;
   logic issued_q;

   always_comb begin
      qualify = mreq_act && ((mode == BWS_ALL_MEM) || fetch_act);
   end

   // wait_q: set for one clock on the first qualifying edge of a cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
      end else begin
         wait_q <= qualify && !issued_q;
      end
   end

   // issued_q: remembers the wait until the memory request ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued_q <= 1'b0;
      end else if (!mreq_act) begin
         issued_q <= 1'b0;
      end else if (qualify) begin
         issued_q <= 1'b1;
      end
   end

   assign wait_act = wait_q;

endmodule

// File: rtl/bws_mem_decode.sv
module bws_mem_decode
   import bws_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SEL_BIT    = 10,
   parameter int RAM_SLICES = 2
) (
   input  logic              mreq_act,
   input  logic              rd_act,
   input  logic              wr_act,
   input  logic [ADDR_W-1:0] addr,
   output bws_sel_t          sel,
   output logic [RAM_SLICES-1:0] ram_slice_sel
);

   generate
      if (SEL_BIT >= ADDR_W) begin : g_bad_sel
         $error("bws_mem_decode: SEL_BIT must be below ADDR_W");
      end
      if (RAM_SLICES < 1) begin : g_bad_slices
         $error("bws_mem_decode: RAM_SLICES must be at least 1");
      end
   endgenerate

   logic upper_half;

   always_comb begin
      upper_half    = addr[SEL_BIT];
      sel.rom_sel   = mreq_act && rd_act && !upper_half;
      sel.ram_sel   = mreq_act && upper_half;
      sel.ram_write = mreq_act && upper_half && wr_act;
   end

   generate
      for (genvar s = 0; s < RAM_SLICES; s++) begin : g_slice
         assign ram_slice_sel[s] = sel.ram_sel;
      end
   endgenerate

endmodule

// File: rtl/bus_wait_stretcher.sv
module bus_wait_stretcher
   import bws_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SEL_BIT    = 10,
   parameter int RAM_SLICES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  m1_n,
   input  logic                  mreq_n,
   input  logic                  rd_n,
   input  logic                  wr_n,
   input  logic                  mode_all_n,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  wait_n,
   output logic                  rom_cs_n,
   output logic [RAM_SLICES-1:0] ram_cs_n,
   output logic                  ram_wr_n
);

   bws_mode_e             mode;
   logic                  wait_act;
   bws_sel_t              sel;
   logic [RAM_SLICES-1:0] slice_sel;

   assign mode = bws_decode_mode(mode_all_n);

   bws_wait_fsm u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .mreq_act  (!mreq_n),
      .fetch_act (!m1_n),
      .mode      (mode),
      .wait_act  (wait_act)
   );

   bws_mem_decode #(
      .ADDR_W     (ADDR_W),
      .SEL_BIT    (SEL_BIT),
      .RAM_SLICES (RAM_SLICES)
   ) u_decode (
      .mreq_act      (!mreq_n),
      .rd_act        (!rd_n),
      .wr_act        (!wr_n),
      .addr          (addr),
      .sel           (sel),
      .ram_slice_sel (slice_sel)
   );

   assign wait_n   = !wait_act;
   assign rom_cs_n = !sel.rom_sel;
   assign ram_cs_n = ~slice_sel;
   assign ram_wr_n = !sel.ram_write;

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
   parameter int ADDR_W     = 16,
   parameter int SEL_BIT    = 10,
   parameter int RAM_SLICES = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  m1_n,
   input logic                  mreq_n,
   input logic                  rd_n,
   input logic                  wr_n,
   input logic                  mode_all_n,
   input logic [ADDR_W-1:0]     addr,
   input logic                  wait_n,
   input logic                  rom_cs_n,
   input logic [RAM_SLICES-1:0] ram_cs_n,
   input logic                  ram_wr_n
);

   logic [1:0] waits_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waits_seen <= 2'd0;
      end else if (mreq_n) begin
         waits_seen <= 2'd0;
      end else if (!wait_n && waits_seen != 2'd3) begin
         waits_seen <= waits_seen + 2'd1;
      end
   end

   a_r1_idle_in_reset: assert property (@(posedge clk) !rst_n |=> wait_n);

   a_r2_one_clock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_n |=> wait_n);

   a_r3_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wait_n) && $past(mode_all_n)) |-> $past(!m1_n));

   a_r4_qualified_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> ($past(!mode_all_n) || $past(!m1_n)));

   a_r5_once_per_request: assert property (@(posedge clk) disable iff (!rst_n)
      waits_seen <= 2'd1);

   a_r6_memory_only: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> $past(!mreq_n));

   a_r7_rom_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs_n |-> !rd_n);

   a_r8_exclusive_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!rom_cs_n, !ram_cs_n[0]}));

   a_r8_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_wr_n |-> (!ram_cs_n[0] && !wr_n));

   a_r10_select_needs_mreq: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_cs_n || !ram_cs_n[0]) |-> !mreq_n);

endmodule

bind bus_wait_stretcher bws_checker #(
   .ADDR_W     (ADDR_W),
   .SEL_BIT    (SEL_BIT),
   .RAM_SLICES (RAM_SLICES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .m1_n       (m1_n),
   .mreq_n     (mreq_n),
   .rd_n       (rd_n),
   .wr_n       (wr_n),
   .mode_all_n (mode_all_n),
   .addr       (addr),
   .wait_n     (wait_n),
   .rom_cs_n   (rom_cs_n),
   .ram_cs_n   (ram_cs_n),
   .ram_wr_n   (ram_wr_n)
);

// File: tb/bus_wait_stretcher_bench.sv
`timescale 1ns/1ps
module bus_wait_stretcher_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m1_n = 1'b1;
   logic        mreq_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        mode_all_n = 1'b1;
   logic [15:0] addr = 16'h0000;
   logic        wait_n;
   logic        rom_cs_n;
   logic [1:0]  ram_cs_n;
   logic        ram_wr_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   bus_wait_stretcher u_bus_wait_stretcher (
      .clk        (clk),
      .rst_n      (rst_n),
      .m1_n       (m1_n),
      .mreq_n     (mreq_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .mode_all_n (mode_all_n),
      .addr       (addr),
      .wait_n     (wait_n),
      .rom_cs_n   (rom_cs_n),
      .ram_cs_n   (ram_cs_n),
      .ram_wr_n   (ram_wr_n)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One memory cycle: strobes driven at a falling edge, held for 'hold' clocks
   task automatic mem_cycle(input string req, input logic fetch, input logic write,
                            input logic [15:0] a, input int hold, input int exp_waits);
      int lows = 0;
      int first = -1;
      @(negedge clk);
      addr   = a;
      m1_n   = !fetch;
      mreq_n = 1'b0;
      rd_n   = write;
      wr_n   = !write;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         if (!wait_n) begin
            lows++;
            if (first < 0) first = i;
         end
      end
      m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      check(req, "wait clocks in cycle", lows, exp_waits);
      if (exp_waits == 1) check(req, "wait in first clock", first, 0);
   endtask

   task automatic io_cycle(input string req);
      int lows = 0;
      @(negedge clk);
      addr = 16'h0410; rd_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (!wait_n) lows++;
      end
      check(req, "io cycle rom_cs_n", rom_cs_n, 1);
      check(req, "io cycle ram_cs_n", ram_cs_n, 2'b11);
      rd_n = 1'b1; wr_n = 1'b0;
      @(negedge clk);
      if (!wait_n) lows++;
      check(req, "io write ram_wr_n", ram_wr_n, 1);
      wr_n = 1'b1;
      check(req, "io cycle wait clocks", lows, 0);
   endtask

   // Decode check between clock edges, no rising edge passes
   task automatic decode(input string req, input logic [15:0] a, input logic rd, input logic wr,
                         input logic mreq, input logic e_rom, input logic [1:0] e_ram, input logic e_wr);
      @(negedge clk);
      addr = a; rd_n = !rd; wr_n = !wr; mreq_n = !mreq;
      #1;
      check(req, $sformatf("rom_cs_n @%h", a), rom_cs_n, e_rom);
      check(req, $sformatf("ram_cs_n @%h", a), ram_cs_n, e_ram);
      check(req, $sformatf("ram_wr_n @%h", a), ram_wr_n, e_wr);
      #1;
      mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R1", "wait_n during reset", wait_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "wait_n after reset", wait_n, 1);
   endtask

   task automatic t_default_mode;
      mode_all_n = 1'b1;
      mem_cycle("R2", 1'b1, 1'b0, 16'h0000, 3, 1);
      mem_cycle("R3", 1'b0, 1'b0, 16'h0100, 3, 0);
      mem_cycle("R3", 1'b0, 1'b1, 16'h0420, 3, 0);
      mem_cycle("R5", 1'b1, 1'b0, 16'h0003, 8, 1);
      mem_cycle("R5", 1'b1, 1'b0, 16'h0004, 2, 1);
      io_cycle("R6");
   endtask

   task automatic t_all_mode;
      @(negedge clk);
      mode_all_n = 1'b0;
      mem_cycle("R4", 1'b1, 1'b0, 16'h0010, 3, 1);
      mem_cycle("R4", 1'b0, 1'b0, 16'h0200, 3, 1);
      mem_cycle("R4", 1'b0, 1'b1, 16'h04FF, 3, 1);
      mem_cycle("R5", 1'b0, 1'b0, 16'h0400, 7, 1);
      io_cycle("R6");
      @(negedge clk);
      mode_all_n = 1'b1;
   endtask

   task automatic t_decode;
      decode("R7",  16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1);
      decode("R7",  16'h03FF, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1);
      decode("R7",  16'h03FF, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1);
      decode("R8",  16'h0400, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
      decode("R8",  16'h04FF, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0);
      decode("R9",  16'h0800, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1);
      decode("R9",  16'hFC00, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
      decode("R10", 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1);
      decode("R10", 16'h0400, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1);
   endtask

   initial begin
      t_reset();
      t_default_mode();
      t_all_mode();
      t_decode();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule